// File: doc/BRIEF.md
# Triggered Reload Down-Counter

This block is a down-counting timer that software or an external pin can start. A four-state controller gates the counter. The states are stopped, armed and waiting for a trigger, loading, and running. A count-enable level moves the timer out of the stopped state. A one-cycle software trigger pulse or a chosen edge on the trigger pin starts a load, which copies the reload register into the counter. The counter then decrements on each cycle where the count-clock enable is high. When it runs past zero, the timer either loads again (reload mode) or goes back to waiting (single-shot mode).

The underflow sets a sticky flag. Software clears the flag with a one-cycle clear pulse, and the flag can raise an interrupt request. The timer output depends on the state. When stopped it passes a plain port level through. When waiting it holds a chosen idle level. When active it is either a run pulse (single-shot) or a level that toggles on each underflow (reload mode). All pins are plain control and status signals. There is no streamed data path, so no valid/ready handshake or back-pressure applies.

Top module: `reload_timer`

## Requirements
- R1: After an asynchronous active-low reset the state is STOP (`tmr_state` = 2'b00), the counter is 0, and the underflow flag and interrupt request are 0.
- R2: On any clock edge where `cnt_en` is low, the state becomes STOP, whatever the current state.
- R3: From STOP with `cnt_en` high, the next state is LOAD (2'b10) if `sw_trig` is high, and WAIT (2'b01) otherwise.
- R4: In WAIT, a `sw_trig` pulse or a selected edge on `ext_trig` leads to LOAD. `edge_sel` selects the edge: 00 none, 01 rising, 10 falling, 11 both. The pin passes through two synchronizer stages, so a pin change made before clock edge k puts the state in LOAD after edge k+2.
- R5: LOAD lasts exactly one cycle while `cnt_en` stays high. On that edge the counter takes the reload register value and the state becomes RUN (2'b11).
- R6: The counter decrements only in RUN, on cycles where `cnt_en` and `tick` are both high. In every other state and cycle it keeps its value, except on the LOAD edge.
- R7: An underflow is a counting cycle in RUN while the counter is 0. The counter wraps to all ones. The next state is LOAD when `reload_mode`=1 and WAIT when `reload_mode`=0.
- R8: A `sw_trig` pulse in RUN sends the timer to LOAD. This takes priority over an underflow on the same cycle.
- R9: An underflow sets `uf_flag`. A `uf_clr` pulse clears it, but an underflow on the same cycle wins. `irq` is high exactly when `uf_flag` and `irq_en` are both high.
- R10: Edges on `ext_trig` have no effect in STOP, LOAD or RUN.
- R11: `tmr_out` takes its value from the state and mode:
  - STOP: equals `port_val`.
  - WAIT: equals `out_pol`.
  - Single-shot mode: equals `out_pol` in LOAD and its inverse in RUN.
  - Reload mode, LOAD and RUN: equals `out_pol` XOR a toggle bit. The toggle bit flips on every underflow and clears in STOP and WAIT.
- R12: A `reload_we` pulse writes `reload_wdata` into the reload register in any state. The counter is not changed until the next LOAD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Count-enable level |
| sw_trig | input | 1 | One-cycle software trigger pulse |
| reload_mode | input | 1 | 1 = reload on underflow, 0 = single-shot |
| reload_we | input | 1 | Reload register write strobe |
| reload_wdata | input | 16 | Reload register write data |
| uf_clr | input | 1 | One-cycle underflow flag clear |
| irq_en | input | 1 | Interrupt request enable |
| out_pol | input | 1 | Idle (initial) level of the timer output |
| edge_sel | input | 2 | External trigger edge select |
| ext_trig | input | 1 | External trigger pin (asynchronous) |
| tick | input | 1 | Count-clock enable |
| port_val | input | 1 | Level driven on the output while stopped |
| tmr_out | output | 1 | Timer output |
| tmr_state | output | 2 | Controller state: 00 STOP, 01 WAIT, 10 LOAD, 11 RUN |
| count | output | 16 | Current counter value |
| uf_flag | output | 1 | Sticky underflow flag |
| irq | output | 1 | Interrupt request |

## Verification
The state, counter, flag and toggle bit are registered, so their response to a register-side input is due one edge after that input is applied. The bench applies each input just after a rising edge and samples 1 ns after the next one. `irq` and `tmr_out` depend on the live inputs as well as on registered state, so the bench checks them in the same cycle in which it changes `irq_en`, `port_val` or `out_pol`. A change on the trigger pin is due three edges later, because of the two synchronizer stages and the state register. The bench checks that the state is still WAIT after the second edge and LOAD after the third.

// File: rtl/reltmr_pkg.sv
package reltmr_pkg;
  typedef enum logic [1:0] {
    ST_STOP = 2'd0,
    ST_WAIT = 2'd1,
    ST_LOAD = 2'd2,
    ST_RUN  = 2'd3
  } tmr_state_e;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_sel_e;
endpackage

// File: rtl/reltmr_trig.sv
module reltmr_trig #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  logic [1:0] edge_sel,
  output logic       edge_hit
);
  import reltmr_pkg::*;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;
  logic                   rise, fall;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[0] <= 1'b0;
        else        sync_q[0] <= pin;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[i] <= 1'b0;
        else        sync_q[i] <= sync_q[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= sync_q[SYNC_STAGES-1];
  end

  assign rise = sync_q[SYNC_STAGES-1] & ~last_q;
  assign fall = ~sync_q[SYNC_STAGES-1] & last_q;

  always_comb begin
    case (edge_sel_e'(edge_sel))
      EDGE_RISE: edge_hit = rise;
      EDGE_FALL: edge_hit = fall;
      EDGE_BOTH: edge_hit = rise | fall;
      default:   edge_hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/reltmr_ctrl.sv
module reltmr_ctrl (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cnt_en,
  input  logic                   sw_trig,
  input  logic                   ext_hit,
  input  logic                   uf_evt,
  input  logic                   reload_mode,
  output reltmr_pkg::tmr_state_e state_q
);
  import reltmr_pkg::*;

  tmr_state_e state_d;

  always_comb begin
    state_d = state_q;
    if (!cnt_en) begin
      state_d = ST_STOP;
    end else begin
      case (state_q)
        ST_STOP: state_d = sw_trig ? ST_LOAD : ST_WAIT;
        ST_WAIT: if (sw_trig || ext_hit) state_d = ST_LOAD;
        ST_LOAD: state_d = ST_RUN;
        ST_RUN: begin
          if (sw_trig)     state_d = ST_LOAD;
          else if (uf_evt) state_d = reload_mode ? ST_LOAD : ST_WAIT;
        end
        default: state_d = ST_STOP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_STOP;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/reltmr_count.sv
module reltmr_count #(
  parameter int W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  reltmr_pkg::tmr_state_e state,
  input  logic                   cnt_en,
  input  logic                   tick,
  input  logic                   reload_we,
  input  logic [W-1:0]           reload_wdata,
  input  logic                   uf_clr,
  output logic [W-1:0]           count_q,
  output logic [W-1:0]           reload_q,
  output logic                   uf_evt,
  output logic                   uf_flag
);
  import reltmr_pkg::*;

  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONE  = W'(1);

  logic step;

  assign step   = (state == ST_RUN) && cnt_en && tick;
  assign uf_evt = step && (count_q == ZERO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         reload_q <= ZERO;
    else if (reload_we) reload_q <= reload_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  count_q <= ZERO;
    else if (state == ST_LOAD)   count_q <= reload_q;
    else if (step)               count_q <= count_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      uf_flag <= 1'b0;
    else if (uf_evt) uf_flag <= 1'b1;
    else if (uf_clr) uf_flag <= 1'b0;
  end
endmodule

// File: rtl/reltmr_out.sv
module reltmr_out (
  input  logic                   clk,
  input  logic                   rst_n,
  input  reltmr_pkg::tmr_state_e state,
  input  logic                   reload_mode,
  input  logic                   out_pol,
  input  logic                   port_val,
  input  logic                   uf_evt,
  output logic                   tmr_out
);
  import reltmr_pkg::*;

  logic tog_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   tog_q <= 1'b0;
    else if (state == ST_STOP || state == ST_WAIT) tog_q <= 1'b0;
    else if (uf_evt && reload_mode)               tog_q <= ~tog_q;
  end

  always_comb begin
    case (state)
      ST_STOP: tmr_out = port_val;
      ST_WAIT: tmr_out = out_pol;
      ST_LOAD: tmr_out = reload_mode ? (out_pol ^ tog_q) : out_pol;
      default: tmr_out = reload_mode ? (out_pol ^ tog_q) : ~out_pol;
    endcase
  end
endmodule

// File: rtl/reload_timer.sv
module reload_timer #(
  parameter int W           = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic         sw_trig,
  input  logic         reload_mode,
  input  logic         reload_we,
  input  logic [W-1:0] reload_wdata,
  input  logic         uf_clr,
  input  logic         irq_en,
  input  logic         out_pol,
  input  logic [1:0]   edge_sel,
  input  logic         ext_trig,
  input  logic         tick,
  input  logic         port_val,
  output logic         tmr_out,
  output logic [1:0]   tmr_state,
  output logic [W-1:0] count,
  output logic         uf_flag,
  output logic         irq
);
  import reltmr_pkg::*;

  tmr_state_e   state_q;
  logic         ext_hit;
  logic         uf_evt;
  logic [W-1:0] reload_q;

  reltmr_trig #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
    .clk(clk), .rst_n(rst_n), .pin(ext_trig), .edge_sel(edge_sel), .edge_hit(ext_hit)
  );

  reltmr_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .sw_trig(sw_trig),
    .ext_hit(ext_hit), .uf_evt(uf_evt), .reload_mode(reload_mode), .state_q(state_q)
  );

  reltmr_count #(.W(W)) u_count (
    .clk(clk), .rst_n(rst_n), .state(state_q), .cnt_en(cnt_en), .tick(tick),
    .reload_we(reload_we), .reload_wdata(reload_wdata), .uf_clr(uf_clr),
    .count_q(count), .reload_q(reload_q), .uf_evt(uf_evt), .uf_flag(uf_flag)
  );

  reltmr_out u_out (
    .clk(clk), .rst_n(rst_n), .state(state_q), .reload_mode(reload_mode),
    .out_pol(out_pol), .port_val(port_val), .uf_evt(uf_evt), .tmr_out(tmr_out)
  );

  assign tmr_state = state_q;
  assign irq       = uf_flag & irq_en;
endmodule

// File: rtl/reltmr_chk.sv
module reltmr_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cnt_en,
  input logic         sw_trig,
  input logic         reload_mode,
  input logic         uf_clr,
  input logic         out_pol,
  input logic         tick,
  input logic         tmr_out,
  input logic [1:0]   tmr_state,
  input logic [W-1:0] count,
  input logic [W-1:0] reload_q,
  input logic         uf_flag
);
  logic uf_now;
  assign uf_now = (tmr_state == 2'd3) && cnt_en && tick && (count == '0);

  assert_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> tmr_state == 2'd0);

  assert_arm_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_state == 2'd0 && cnt_en && !sw_trig) |=> tmr_state == 2'd1);

  assert_load_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_state == 2'd2 && cnt_en) |=> tmr_state == 2'd3);

  assert_load_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_state == 2'd2) |=> count == $past(reload_q));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_state != 2'd2 && !(tmr_state == 2'd3 && cnt_en && tick)) |=> $stable(count));

  assert_oneshot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (uf_now && !sw_trig && !reload_mode) |=> tmr_state == 2'd1);

  assert_flag_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    uf_now |=> uf_flag);

  assert_flag_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (uf_clr && !uf_now) |=> !uf_flag);

  assert_wait_out_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_state == 2'd1) |-> tmr_out == out_pol);
endmodule

bind reload_timer reltmr_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .sw_trig(sw_trig),
  .reload_mode(reload_mode), .uf_clr(uf_clr), .out_pol(out_pol), .tick(tick),
  .tmr_out(tmr_out), .tmr_state(tmr_state), .count(count), .reload_q(reload_q),
  .uf_flag(uf_flag)
);

// File: tb/sim_reload_timer.sv
`timescale 1ns/1ps
module sim_reload_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnt_en = 0, sw_trig = 0, reload_mode = 1, reload_we = 0, uf_clr = 0;
  logic irq_en = 0, out_pol = 0, ext_trig = 0, tick = 0, port_val = 0;
  logic [1:0] edge_sel = 2'd0;
  logic [15:0] reload_wdata = 16'h0;
  logic tmr_out, uf_flag, irq;
  logic [1:0] tmr_state;
  logic [15:0] count;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  reload_timer u0 (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .sw_trig(sw_trig),
    .reload_mode(reload_mode), .reload_we(reload_we), .reload_wdata(reload_wdata),
    .uf_clr(uf_clr), .irq_en(irq_en), .out_pol(out_pol), .edge_sel(edge_sel),
    .ext_trig(ext_trig), .tick(tick), .port_val(port_val), .tmr_out(tmr_out),
    .tmr_state(tmr_state), .count(count), .uf_flag(uf_flag), .irq(irq)
  );

  // {cnt_en, sw_trig, tick, exp_state[1:0], exp_flag, exp_count[15:0]}
  localparam logic [21:0] VEC [0:16] = '{
    {3'b100, 2'd1, 1'b0, 16'h0000},
    {3'b101, 2'd1, 1'b0, 16'h0000},
    {3'b110, 2'd2, 1'b0, 16'h0000},
    {3'b100, 2'd3, 1'b0, 16'h0003},
    {3'b101, 2'd3, 1'b0, 16'h0002},
    {3'b100, 2'd3, 1'b0, 16'h0002},
    {3'b101, 2'd3, 1'b0, 16'h0001},
    {3'b101, 2'd3, 1'b0, 16'h0000},
    {3'b101, 2'd2, 1'b1, 16'hFFFF},
    {3'b100, 2'd3, 1'b1, 16'h0003},
    {3'b110, 2'd2, 1'b1, 16'h0003},
    {3'b101, 2'd3, 1'b1, 16'h0003},
    {3'b101, 2'd3, 1'b1, 16'h0002},
    {3'b001, 2'd0, 1'b1, 16'h0002},
    {3'b011, 2'd0, 1'b1, 16'h0002},
    {3'b110, 2'd2, 1'b1, 16'h0002},
    {3'b100, 2'd3, 1'b1, 16'h0003}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic e, input logic t, input logic k);
    cnt_en = e; sw_trig = t; tick = k;
    @(posedge clk); #1;
    sw_trig = 0; uf_clr = 0; reload_we = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 state", tmr_state, 2'd0);
    check("R1 count", count, 16'h0);
    check("R1 flag", uf_flag, 1'b0);
    check("R1 irq", irq, 1'b0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    // R12 reload written while stopped
    reload_wdata = 16'd3; reload_we = 1;
    step(0, 0, 0);
    check("R12 no count change", count, 16'h0);

    // table walk: R2 R3 R5 R6 R7 R8
    for (int i = 0; i < 17; i++) begin
      logic [21:0] v;
      v = VEC[i];
      step(v[21], v[20], v[19]);
      check("R2/R3/R5/R6/R7/R8 state", tmr_state, v[18:17]);
      check("R9 flag", uf_flag, v[16]);
      check("R6/R7 count", count, v[15:0]);
    end

    // R9 irq and clear
    irq_en = 1; #1;
    check("R9 irq on", irq, 1'b1);
    uf_clr = 1;
    step(1, 0, 0);
    check("R9 cleared", uf_flag, 1'b0);
    check("R9 irq off", irq, 1'b0);

    // R2 stop, R11 port pass-through
    step(0, 0, 0);
    check("R2 stop", tmr_state, 2'd0);
    port_val = 1; #1;
    check("R11 stop out", tmr_out, 1'b1);

    // R10 pin edges ignored in STOP
    edge_sel = 2'd1; ext_trig = 1;
    for (int i = 0; i < 4; i++) step(0, 0, 0);
    check("R10 stop ignores pin", tmr_state, 2'd0);
    ext_trig = 0;
    for (int i = 0; i < 3; i++) step(0, 0, 0);
    step(1, 0, 0);
    check("R3 arm", tmr_state, 2'd1);

    // R4 rising edge, three edges of latency
    ext_trig = 1;
    step(1, 0, 0);
    step(1, 0, 0);
    check("R4 still waiting", tmr_state, 2'd1);
    step(1, 0, 0);
    check("R4 rising edge load", tmr_state, 2'd2);
    step(1, 0, 0);
    check("R4 run", count, 16'd3);

    // R12 write during RUN, R8 restart
    reload_wdata = 16'd5; reload_we = 1;
    step(1, 0, 0);
    check("R12 count untouched", count, 16'd3);
    step(1, 1, 0);
    check("R8 restart", tmr_state, 2'd2);
    step(1, 0, 0);
    check("R12 new value", count, 16'd5);

    // R4 falling edge
    edge_sel = 2'd2;
    step(0, 0, 0);
    step(1, 0, 0);
    ext_trig = 0;
    step(1, 0, 0);
    step(1, 0, 0);
    check("R4 fall still waiting", tmr_state, 2'd1);
    step(1, 0, 0);
    check("R4 falling edge load", tmr_state, 2'd2);

    // R7 single-shot, R11 pulse output
    step(0, 0, 0);
    reload_wdata = 16'd1; reload_we = 1; reload_mode = 0; out_pol = 0;
    step(0, 0, 0);
    step(1, 0, 0);
    check("R11 wait out", tmr_out, 1'b0);
    step(1, 1, 0);
    check("R11 oneshot load out", tmr_out, 1'b0);
    step(1, 0, 0);
    check("R11 oneshot run out", tmr_out, 1'b1);
    step(1, 0, 1);
    check("R6 count", count, 16'd0);
    step(1, 0, 1);
    check("R7 oneshot to wait", tmr_state, 2'd1);
    check("R7 wrap", count, 16'hFFFF);
    check("R11 oneshot idle", tmr_out, 1'b0);

    // R11 reload-mode toggle
    reload_mode = 1; out_pol = 1; reload_wdata = 16'd0; reload_we = 1;
    step(0, 0, 0);
    step(1, 1, 0);
    check("R11 toggle load out", tmr_out, 1'b1);
    step(1, 0, 0);
    check("R11 toggle run out", tmr_out, 1'b1);
    step(1, 0, 1);
    check("R7 reload to load", tmr_state, 2'd2);
    check("R11 toggled", tmr_out, 1'b0);
    step(1, 0, 0);
    check("R11 toggled run", tmr_out, 1'b0);
    uf_clr = 1;
    step(1, 0, 0);
    check("R9 clear before race", uf_flag, 1'b0);
    uf_clr = 1;
    step(1, 0, 1);
    check("R9 set wins", uf_flag, 1'b1);
    check("R11 toggled back", tmr_out, 1'b1);

    finish_run();
  end
endmodule